// File: doc/BRIEF.md
# DMA Request Synchronization Gate

This block sits on a single peripheral DMA request line and decides when that request may reach the DMA controller. While gating is enabled, a request line is forwarded only inside a window. An edge on a chosen synchronization input opens the window. The window closes once a programmed number of requests has been accepted downstream. A request counts as accepted when the downstream acknowledge is seen while the gated request is high.

Configuration is presented as static inputs. These select:
- which synchronization source to use,
- which edge direction counts,
- whether gating is enabled,
- whether a completion event is generated,
- the window length, stored as length minus one.

The synchronization inputs are asynchronous, so each one passes through a two-flop synchronizer before edge detection. The completion event is a one-clock pulse. It can be wired back into the source bank of another channel, so several channels can be chained. A source index outside the bank is flagged as a configuration error and never opens a window. A synchronization edge that arrives while a window is already open is discarded and sets a sticky overrun flag.

Top module: `dsg_sync_gate`

## Requirements
- R1: After reset, req_o, evt_o and ovr_o are 0.
- R2: With cfg_sync_en_i = 0, req_o equals req_i in the same cycle, evt_o stays 0 and the window state is cleared.
- R3: With cfg_sync_en_i = 1 and no window open, req_o is 0 whatever req_i is.
- R4: With cfg_pol_i = 2'b01, a 0-to-1 change on the selected sync input opens a window, and req_o follows req_i from the third rising clock edge after the change. A 1-to-0 change opens nothing.
- R5: With cfg_pol_i = 2'b10, only a 1-to-0 change opens a window, with the same latency as R4.
- R6: With cfg_pol_i = 2'b11, both 0-to-1 and 1-to-0 changes open a window.
- R7: With cfg_pol_i = 2'b00, no change on the sync input opens a window.
- R8: A window forwards exactly cfg_req_num_i + 1 requests, counted on cycles where req_o and ack_i are both 1. Cycles with ack_i = 0 do not count. The window closes at the clock edge that accepts the last request. A field value of 31 gives 32 requests.
- R9: With cfg_evt_en_i = 1, evt_o is high for exactly one cycle, in the cycle after the last request of a window was accepted. With cfg_evt_en_i = 0, evt_o stays 0.
- R10: A qualifying sync edge while a window is open is ignored for the window and sets ovr_o. ovr_o stays 1 until cfg_sync_en_i is cleared.
- R11: A source index cfg_src_sel_i >= NUM_SRC (8 by default) drives cfg_err_o to 1, and no sync activity opens a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_src_sel_i | input | SEL_W (5) | Sync source index |
| cfg_pol_i | input | 2 | Edge select: 00 none, 01 rising, 10 falling, 11 both |
| cfg_sync_en_i | input | 1 | Gating enable |
| cfg_evt_en_i | input | 1 | Completion event enable |
| cfg_req_num_i | input | CNT_W (5) | Window length minus one |
| sync_i | input | NUM_SRC (8) | Asynchronous sync source bank |
| req_i | input | 1 | Raw peripheral request |
| ack_i | input | 1 | Downstream acknowledge |
| req_o | output | 1 | Gated request |
| evt_o | output | 1 | One-cycle completion event |
| ovr_o | output | 1 | Sticky overrun flag |
| cfg_err_o | output | 1 | Source index out of range |

## Verification
The gated request is combinational in the window state and req_i. A sync change therefore shows on req_o only after three rising edges: two synchronizer stages and the window register. The bench drives inputs at the falling edge and samples req_o exactly three falling edges after the change. The completion pulse is registered on the edge that accepts the last request, so it is checked one sampled cycle after the last forwarded sample, and also that it is gone in the next one. The overrun flag is checked after the same three-edge latency, and again one edge after gating is cleared.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_RISE = 2'b01,
    POL_FALL = 2'b10,
    POL_BOTH = 2'b11
  } pol_e;
endpackage

// File: rtl/dsg_sync_bank.sv
module dsg_sync_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] async_i,
  output logic [NUM_SRC-1:0] sync_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/dsg_edge_sel.sv
module dsg_edge_sel
  import dsg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] sync_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [1:0]         pol_i,
  input  logic               en_i,
  output logic               hit_o,
  output logic               err_o
);
  logic sig, prev_q, valid, rise, fall;
  pol_e pol;

  assign valid = 32'(sel_i) < NUM_SRC;
  assign err_o = ~valid;
  assign pol   = pol_e'(pol_i);

  always_comb begin
    sig = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel_i == SEL_W'(i)) sig = sync_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;

  always_comb begin
    unique case (pol)
      POL_RISE: hit_o = rise;
      POL_FALL: hit_o = fall;
      POL_BOTH: hit_o = rise | fall;
      default:  hit_o = 1'b0;
    endcase
    hit_o = hit_o & valid & en_i;
  end
endmodule

// File: rtl/dsg_window.sv
module dsg_window #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_en_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             hit_i,
  input  logic             req_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic             evt_o,
  output logic             ovr_o,
  output logic             open_o
);
  logic             open_q, evt_q, ovr_q, fwd;
  logic [CNT_W-1:0] cnt_q;

  assign req_o  = en_i ? (req_i & open_q) : req_i;
  assign fwd    = en_i & open_q & req_i & ack_i;
  assign evt_o  = evt_q;
  assign ovr_o  = ovr_q;
  assign open_o = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      evt_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (!en_i) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
        ovr_q  <= 1'b0;
      end else begin
        if (fwd) begin
          if (cnt_q == lim_i) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            evt_q  <= evt_en_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        // edge during an open window is dropped
        if (hit_i) begin
          if (open_q) ovr_q <= 1'b1;
          else begin
            open_q <= 1'b1;
            cnt_q  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsg_sync_gate.sv
module dsg_sync_gate #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 5,
  parameter int CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   cfg_src_sel_i,
  input  logic [1:0]         cfg_pol_i,
  input  logic               cfg_sync_en_i,
  input  logic               cfg_evt_en_i,
  input  logic [CNT_W-1:0]   cfg_req_num_i,
  input  logic [NUM_SRC-1:0] sync_i,
  input  logic               req_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic               evt_o,
  output logic               ovr_o,
  output logic               cfg_err_o
);
  logic [NUM_SRC-1:0] sync_q;
  logic               hit, win_open;

  dsg_sync_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i, .rst_ni, .async_i(sync_i), .sync_o(sync_q)
  );

  dsg_edge_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_edge (
    .clk_i, .rst_ni, .sync_i(sync_q), .sel_i(cfg_src_sel_i),
    .pol_i(cfg_pol_i), .en_i(cfg_sync_en_i), .hit_o(hit), .err_o(cfg_err_o)
  );

  dsg_window #(.CNT_W(CNT_W)) u_win (
    .clk_i, .rst_ni, .en_i(cfg_sync_en_i), .evt_en_i(cfg_evt_en_i),
    .lim_i(cfg_req_num_i), .hit_i(hit), .req_i, .ack_i,
    .req_o, .evt_o, .ovr_o, .open_o(win_open)
  );
endmodule

// File: rtl/dsg_sync_gate_chk.sv
module dsg_sync_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_sync_en_i,
  input logic req_i,
  input logic ack_i,
  input logic req_o,
  input logic evt_o,
  input logic ovr_o,
  input logic win_open
);
  // R2
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_sync_en_i |-> (req_o == req_i));

  // R3
  closed_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sync_en_i && !win_open) |-> !req_o);

  // R9
  evt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);

  // R9
  evt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> $past(req_o && ack_i && cfg_sync_en_i));

  // R10
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && cfg_sync_en_i) |=> ovr_o);
endmodule

bind dsg_sync_gate dsg_sync_gate_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_sync_en_i(cfg_sync_en_i),
  .req_i(req_i), .ack_i(ack_i), .req_o(req_o), .evt_o(evt_o),
  .ovr_o(ovr_o), .win_open(win_open)
);

// File: tb/dsg_sync_gate_test.sv
`timescale 1ns/1ps
module dsg_sync_gate_test;
  localparam int NUM_SRC = 8;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0] cfg_src_sel_i = '0;
  logic [1:0] cfg_pol_i = '0;
  logic       cfg_sync_en_i = 1'b0, cfg_evt_en_i = 1'b0;
  logic [4:0] cfg_req_num_i = '0;
  logic [NUM_SRC-1:0] sync_i = '0;
  logic       req_i = 1'b0, ack_i = 1'b0;
  logic       req_o, evt_o, ovr_o, cfg_err_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  dsg_sync_gate uut (.*);

  // {pol, start level, end level, window expected}
  localparam logic [4:0] VEC [8] = '{
    {2'b01, 1'b0, 1'b1, 1'b1}, {2'b01, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1}, {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b0, 1'b1},
    {2'b00, 1'b0, 1'b1, 1'b0}, {2'b00, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic open_rise(int sel);
    cfg_sync_en_i = 1'b0; sync_i = '0; req_i = 1'b0; ack_i = 1'b0;
    cyc(4);
    cfg_src_sel_i = 5'(sel); cfg_pol_i = 2'b01; cfg_sync_en_i = 1'b1;
    cyc(1);
    sync_i[sel] = 1'b1;
    cyc(3);
  endtask

  // returns forwarded count, event count, event placement ok
  task automatic run_win(int field, bit een, output int fwd, output int evts, output bit evt_ok);
    int last = -10;
    cfg_req_num_i = 5'(field); cfg_evt_en_i = een;
    open_rise(3);
    fwd = 0; evts = 0; evt_ok = 1'b1;
    req_i = 1'b1;
    for (int i = 0; i < field + 8; i++) begin
      ack_i = (i >= 2);
      #0.5;
      if (evt_o) begin
        evts++;
        if (i != last + 1) evt_ok = 1'b0;
      end
      if (req_o && ack_i) begin fwd++; last = i; end
      @(negedge clk_i);
    end
    req_i = 1'b0; ack_i = 1'b0;
  endtask

  initial begin
    int f, e;
    bit ok;
    cyc(2);
    check("R1 req_o", int'(req_o), 0);
    check("R1 evt_o", int'(evt_o), 0);
    check("R1 ovr_o", int'(ovr_o), 0);
    rst_ni = 1'b1;
    cyc(2);

    // R2 bypass
    req_i = 1'b1; #0.5;
    check("R2 pass high", int'(req_o), 1);
    req_i = 1'b0; #0.5;
    check("R2 pass low", int'(req_o), 0);
    check("R2 no evt", int'(evt_o), 0);

    // R3 closed window
    cfg_sync_en_i = 1'b1; cfg_pol_i = 2'b01; cfg_src_sel_i = 5'd1;
    cyc(1);
    req_i = 1'b1; cyc(2);
    check("R3 closed blocks", int'(req_o), 0);
    req_i = 1'b0;

    // R4 R5 R6 R7 polarity table, source 5
    foreach (VEC[k]) begin
      cfg_sync_en_i = 1'b0; cfg_req_num_i = 5'd31;
      sync_i[5] = VEC[k][2]; cyc(5);
      cfg_src_sel_i = 5'd5; cfg_pol_i = VEC[k][4:3]; cfg_sync_en_i = 1'b1;
      req_i = 1'b1; cyc(1);
      sync_i[5] = VEC[k][1];
      cyc(2);
      check($sformatf("R4/R5/R6/R7 vec%0d pre-latency", k), int'(req_o), 0);
      cyc(1);
      check($sformatf("R4/R5/R6/R7 vec%0d pol=%0d window", k, VEC[k][4:3]),
            int'(req_o), int'(VEC[k][0]));
      req_i = 1'b0;
    end

    // R8 R9 count and event
    run_win(3, 1'b1, f, e, ok);
    check("R8 forwarded N=4", f, 4);
    check("R9 one event", e, 1);
    check("R9 event after last ack", int'(ok), 1);
    run_win(0, 1'b0, f, e, ok);
    check("R8 forwarded N=1", f, 1);
    check("R9 no event when disabled", e, 0);
    run_win(31, 1'b1, f, e, ok);
    check("R8 forwarded N=32", f, 32);
    check("R9 event N=32", e, 1);

    // R10 overrun
    cfg_req_num_i = 5'd31; cfg_evt_en_i = 1'b0;
    open_rise(2);
    check("R10 no overrun yet", int'(ovr_o), 0);
    sync_i[2] = 1'b0; cyc(3);
    sync_i[2] = 1'b1; cyc(3);
    check("R10 overrun set", int'(ovr_o), 1);
    req_i = 1'b1; #0.5;
    check("R10 window still open", int'(req_o), 1);
    req_i = 1'b0;
    cyc(4);
    check("R10 overrun sticky", int'(ovr_o), 1);
    cfg_sync_en_i = 1'b0; cyc(1);
    check("R10 cleared by disable", int'(ovr_o), 0);

    // R11 invalid index
    cfg_src_sel_i = 5'd9; cfg_pol_i = 2'b11; cfg_sync_en_i = 1'b1; #0.5;
    check("R11 err flag", int'(cfg_err_o), 1);
    req_i = 1'b1;
    sync_i = '1; cyc(4);
    sync_i = '0; cyc(4);
    check("R11 no window", int'(req_o), 0);
    cfg_src_sel_i = 5'd7; #0.5;
    check("R11 err clear at top index", int'(cfg_err_o), 0);
    req_i = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule